// File: doc/BRIEF.md
# Cartridge DMA Controller

This block lets software move a run of bytes between main DRAM and a cartridge bus without touching each byte. Software sets a DRAM byte address and a cartridge byte address, then writes one of two length registers. The register it writes picks the direction. The block copies the bytes one at a time through two simple request/acknowledge memory ports. It then moves both address registers past the block it copied, each with its own alignment rule. This lets a follow-on transfer continue without software setting the addresses again.

After the last byte is stored, the block stays busy for a while. That time models the cartridge bus and comes from a per-domain set of four timing registers: access latency, strobe pulse width, page size and release time. When the wait ends, the busy flag clears and an interrupt becomes pending in the same clock. The pending flag stays set until software clears it through the status register. Decoding of cartridge regions and the memories themselves live outside this block. The only decode the block does is on the top byte of the cartridge address, which selects the timing domain.

Top module: `cart_dma_ctrl`

## Requirements
- R1: After reset, every register (word indices 0 to 12) reads zero, `irq` is low and neither memory port makes a request.
- R2: The DRAM address register (word 0) keeps 24 bits with bit 0 forced to 0, which is a mask of 0x00FFFFFE. The cartridge address register (word 1) keeps 32 bits with bit 0 forced to 0, which is a mask of 0xFFFFFFFE.
- R3: The length registers (word 2 and word 3) keep only the low 24 bits of a write. A transfer moves exactly the stored value plus one bytes. Byte k goes from source base plus k to destination base plus k.
- R4: A write to word 2 starts a transfer from DRAM to the cartridge. A write to word 3 starts a transfer from the cartridge to DRAM.
- R5: When a transfer of n bytes ends, the DRAM address becomes base plus n rounded up to a multiple of 8, kept to 24 bits. The cartridge address becomes base plus n rounded up to an even value.
- R6: The status register (word 4) reads bit 0 as DMA busy, bit 1 as IO busy (always 0), bit 2 as IO error (always 0) and bit 3 as interrupt pending. All other bits read 0.
- R7: DMA busy rises on the clock edge that takes a length write and stays set while bytes move. It then stays set for a further D cycles after the last byte is stored. Busy falls and `irq` rises on the same edge. The wait is D = (lat+20)·ceil(n/2^(pgs+2)) + (pwd+rls+2)·floor(n/2), using the four timing fields of the selected domain. With memories that acknowledge at once, `irq` rises 2n+D edges after the length write.
- R8: A status write with bit 1 set clears the pending interrupt. A status write with bit 1 clear leaves the pending interrupt as it was.
- R9: A length write that arrives while DMA busy is set is ignored. The length register keeps its value and no transfer starts.
- R10: The eight timing registers sit at word indices 5 to 12 and each keeps 8 bits. The order is latency, pulse width, page size and release for domain 1, then the same four for domain 2. Domain 2 is used when the top byte of the cartridge address at the start of a transfer equals `DOM2_TAG` (0x08). Any other top byte uses domain 1.
- R11: A memory request, with its address, is held until it is acknowledged. The two ports never request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_word | input | 4 | Register word index |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register at `reg_word` (combinational) |
| dram_req | output | 1 | DRAM byte request |
| dram_we | output | 1 | DRAM request is a write |
| dram_addr | output | 24 | DRAM byte address |
| dram_wdata | output | 8 | DRAM write byte |
| dram_rdata | input | 8 | DRAM read byte, valid with `dram_ack` |
| dram_ack | input | 1 | DRAM request accepted |
| cart_req | output | 1 | Cartridge byte request |
| cart_we | output | 1 | Cartridge request is a write |
| cart_addr | output | 32 | Cartridge byte address |
| cart_wdata | output | 8 | Cartridge write byte |
| cart_rdata | input | 8 | Cartridge read byte, valid with `cart_ack` |
| cart_ack | input | 1 | Cartridge request accepted |
| irq | output | 1 | Interrupt pending |

## Verification
The assertions check, on every cycle, properties that need no arithmetic. A stalled request holds its address. The two ports never request together. Busy never falls without the interrupt rising. A length write during busy leaves both length registers unchanged. An interrupt clear takes effect. Address bit 0 stays clear. The wait counter never sits at zero while active. The bench scenarios are the only place where the copied bytes, the address rounding and the exact delay formula can be shown. They sweep transfer lengths, both directions, both timing domains, and memories that stall or answer at once, and they compare against values the bench computes itself.

// File: rtl/cdma_pkg.sv
package cdma_pkg;

    // Register word indices; the timing block must stay contiguous in this order
    localparam logic [3:0] W_DRAM   = 4'd0;
    localparam logic [3:0] W_CART   = 4'd1;
    localparam logic [3:0] W_RDLEN  = 4'd2;
    localparam logic [3:0] W_WRLEN  = 4'd3;
    localparam logic [3:0] W_STAT   = 4'd4;
    localparam int unsigned TIM_BASE  = 5;
    localparam int unsigned TIM_COUNT = 8;
    localparam int unsigned STAT_CLR_BIT = 1;

    // Fixed bus-cycle overhead per page: 14 setup plus 5 teardown plus the latency bias
    localparam int unsigned PAGE_OVERHEAD = 20;

    typedef enum logic [1:0] {
        MV_IDLE  = 2'd0,
        MV_FETCH = 2'd1,
        MV_STORE = 2'd2
    } mv_state_e;

    typedef enum logic {
        DIR_TO_CART = 1'b0,
        DIR_TO_DRAM = 1'b1
    } xfer_dir_e;

    typedef struct packed {
        logic [7:0] lat;
        logic [7:0] pwd;
        logic [7:0] pgs;
        logic [7:0] rls;
    } dom_timing_t;

    // Bus-hold cycles for a transfer of n bytes under one domain's timing
    function automatic logic [47:0] calc_delay(input dom_timing_t t, input logic [31:0] n);
        logic [31:0]  nm1;
        logic [47:0]  pages;
        int unsigned  sh;
        nm1   = n - 32'd1;
        sh    = 32'(t.pgs) + 32'd2;
        pages = 48'(nm1 >> sh) + 48'd1;
        return (48'(t.lat) + 48'(PAGE_OVERHEAD)) * pages
             + (48'(t.pwd) + 48'(t.rls) + 48'd2) * 48'(n >> 1);
    endfunction

endpackage

// File: rtl/cdma_regfile.sv
module cdma_regfile
    import cdma_pkg::*;
#(
    parameter int unsigned DRAM_AW = 24,
    parameter int unsigned CART_AW = 32,
    parameter int unsigned LEN_W   = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [3:0]         reg_word,
    input  logic               reg_we,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               busy,
    input  logic               done,
    input  logic [DRAM_AW-1:0] dram_next,
    input  logic [CART_AW-1:0] cart_next,
    input  logic               expire,
    output logic               go,
    output xfer_dir_e          go_dir,
    output logic [LEN_W-1:0]   go_len,
    output logic [DRAM_AW-1:0] dram_q,
    output logic [CART_AW-1:0] cart_q,
    output dom_timing_t        tim_dom1,
    output dom_timing_t        tim_dom2,
    output logic               irq
);

    logic [LEN_W-1:0] rdlen_q;
    logic [LEN_W-1:0] wrlen_q;
    logic [7:0]       tim_q [TIM_COUNT];
    logic             start_rd;
    logic             start_wr;
    logic             clr_req;

    assign start_rd = reg_we && (reg_word == W_RDLEN) && !busy;
    assign start_wr = reg_we && (reg_word == W_WRLEN) && !busy;
    assign clr_req  = reg_we && (reg_word == W_STAT) && reg_wdata[STAT_CLR_BIT];

    assign go     = start_rd || start_wr;
    assign go_dir = start_wr ? DIR_TO_DRAM : DIR_TO_CART;
    assign go_len = reg_wdata[LEN_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            dram_q  <= '0;
            cart_q  <= '0;
            rdlen_q <= '0;
            wrlen_q <= '0;
            irq     <= 1'b0;
        end else begin
            if (done) begin
                dram_q <= dram_next;
                cart_q <= cart_next;
            end else begin
                if (reg_we && reg_word == W_DRAM)
                    dram_q <= reg_wdata[DRAM_AW-1:0] & ~DRAM_AW'(1);
                if (reg_we && reg_word == W_CART)
                    cart_q <= reg_wdata[CART_AW-1:0] & ~CART_AW'(1);
            end
            if (start_rd) rdlen_q <= reg_wdata[LEN_W-1:0];
            if (start_wr) wrlen_q <= reg_wdata[LEN_W-1:0];
            if (expire)       irq <= 1'b1;
            else if (clr_req) irq <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < int'(TIM_COUNT); i++) begin
            if (rst)
                tim_q[i] <= '0;
            else if (reg_we && reg_word == 4'(TIM_BASE + i))
                tim_q[i] <= reg_wdata[7:0];
        end
    end

    // Domain timing views; field order within each domain follows the word order
    for (genvar d = 0; d < 2; d++) begin : g_dom
        dom_timing_t view;
        assign view = '{lat: tim_q[4*d],   pwd: tim_q[4*d+1],
                        pgs: tim_q[4*d+2], rls: tim_q[4*d+3]};
        if (d == 0) begin : g_d1
            assign tim_dom1 = view;
        end else begin : g_d2
            assign tim_dom2 = view;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_word)
            W_DRAM:  reg_rdata = 32'(dram_q);
            W_CART:  reg_rdata = 32'(cart_q);
            W_RDLEN: reg_rdata = 32'(rdlen_q);
            W_WRLEN: reg_rdata = 32'(wrlen_q);
            W_STAT:  reg_rdata = {28'd0, irq, 1'b0, 1'b0, busy};
            default: begin
                if (reg_word >= 4'(TIM_BASE) && reg_word < 4'(TIM_BASE + TIM_COUNT))
                    reg_rdata = {24'd0, tim_q[3'(reg_word - 4'(TIM_BASE))]};
            end
        endcase
    end

    // R9
    len_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we && busy && (reg_word == W_RDLEN || reg_word == W_WRLEN))
        |=> ($stable(rdlen_q) && $stable(wrlen_q)));

    // R8
    irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !expire) |=> !irq);

    // R2
    addr_even_chk: assert property (@(posedge clk) disable iff (rst)
        (dram_q[0] == 1'b0) && (cart_q[0] == 1'b0));

endmodule

// File: rtl/cdma_mover.sv
module cdma_mover
    import cdma_pkg::*;
#(
    parameter int unsigned DRAM_AW = 24,
    parameter int unsigned CART_AW = 32,
    parameter int unsigned LEN_W   = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               go,
    input  xfer_dir_e          go_dir,
    input  logic [LEN_W-1:0]   go_len,
    input  logic [DRAM_AW-1:0] dram_base,
    input  logic [CART_AW-1:0] cart_base,
    output logic               dram_req,
    output logic               dram_we,
    output logic [DRAM_AW-1:0] dram_addr,
    output logic [7:0]         dram_wdata,
    input  logic [7:0]         dram_rdata,
    input  logic               dram_ack,
    output logic               cart_req,
    output logic               cart_we,
    output logic [CART_AW-1:0] cart_addr,
    output logic [7:0]         cart_wdata,
    input  logic [7:0]         cart_rdata,
    input  logic               cart_ack,
    output logic               active,
    output logic               done,
    output logic [DRAM_AW-1:0] dram_next,
    output logic [CART_AW-1:0] cart_next,
    output logic [7:0]         xfer_tag,
    output logic [LEN_W:0]     xfer_n
);

    mv_state_e          st;
    xfer_dir_e          dir_q;
    logic [DRAM_AW-1:0] dbase;
    logic [CART_AW-1:0] cbase;
    logic [LEN_W-1:0]   last_q;
    logic [LEN_W-1:0]   idx;
    logic [7:0]         byte_q;
    logic               src_ack;
    logic [7:0]         src_data;
    logic               dst_ack;
    logic               last;

    assign active = (st != MV_IDLE);
    assign xfer_n = {1'b0, last_q} + (LEN_W+1)'(1);
    assign xfer_tag = cbase[CART_AW-1 -: 8];

    assign dram_addr  = dbase + DRAM_AW'(idx);
    assign cart_addr  = cbase + CART_AW'(idx);
    assign dram_wdata = byte_q;
    assign cart_wdata = byte_q;

    assign dram_req = (st == MV_FETCH && dir_q == DIR_TO_CART) ||
                      (st == MV_STORE && dir_q == DIR_TO_DRAM);
    assign cart_req = (st == MV_FETCH && dir_q == DIR_TO_DRAM) ||
                      (st == MV_STORE && dir_q == DIR_TO_CART);
    assign dram_we  = (st == MV_STORE);
    assign cart_we  = (st == MV_STORE);

    assign src_ack  = (dir_q == DIR_TO_CART) ? dram_ack : cart_ack;
    assign src_data = (dir_q == DIR_TO_CART) ? dram_rdata : cart_rdata;
    assign dst_ack  = (dir_q == DIR_TO_CART) ? cart_ack : dram_ack;
    assign last     = (idx == last_q);
    assign done     = (st == MV_STORE) && dst_ack && last;

    // Post-transfer alignment: DRAM rounds to 8 bytes, cartridge to 2 bytes
    assign dram_next = (dbase + DRAM_AW'(xfer_n) + DRAM_AW'(7)) & ~DRAM_AW'(7);
    assign cart_next = (cbase + CART_AW'(xfer_n) + CART_AW'(1)) & ~CART_AW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= MV_IDLE;
            dir_q  <= DIR_TO_CART;
            dbase  <= '0;
            cbase  <= '0;
            last_q <= '0;
            idx    <= '0;
            byte_q <= '0;
        end else begin
            case (st)
                MV_IDLE: begin
                    if (go) begin
                        dir_q  <= go_dir;
                        dbase  <= dram_base;
                        cbase  <= cart_base;
                        last_q <= go_len;
                        idx    <= '0;
                        st     <= MV_FETCH;
                    end
                end
                MV_FETCH: begin
                    if (src_ack) begin
                        byte_q <= src_data;
                        st     <= MV_STORE;
                    end
                end
                MV_STORE: begin
                    if (dst_ack) begin
                        if (last) begin
                            st <= MV_IDLE;
                        end else begin
                            idx <= idx + LEN_W'(1);
                            st  <= MV_FETCH;
                        end
                    end
                end
                default: st <= MV_IDLE;
            endcase
        end
    end

    // R11
    one_port_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({dram_req, cart_req}));

    // R11
    dram_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (dram_req && !dram_ack) |=> (dram_req && $stable(dram_addr) && $stable(dram_we)));

    // R11
    cart_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cart_req && !cart_ack) |=> (cart_req && $stable(cart_addr) && $stable(cart_we)));

endmodule

// File: rtl/cdma_delay.sv
module cdma_delay
    import cdma_pkg::*;
#(
    parameter int unsigned LEN_W    = 24,
    parameter int unsigned DLY_W    = 40,
    parameter logic [7:0]  DOM2_TAG = 8'h08
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          done,
    input  logic [7:0]    xfer_tag,
    input  logic [LEN_W:0] xfer_n,
    input  dom_timing_t   tim_dom1,
    input  dom_timing_t   tim_dom2,
    output logic          active,
    output logic          expire
);

    dom_timing_t      sel;
    logic [DLY_W-1:0] span;
    logic [DLY_W-1:0] cnt;

    assign sel    = (xfer_tag == DOM2_TAG) ? tim_dom2 : tim_dom1;
    assign span   = DLY_W'(calc_delay(sel, 32'(xfer_n)));
    assign expire = active && (cnt == DLY_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (done) begin
            active <= 1'b1;
            cnt    <= span;
        end else if (active) begin
            if (cnt == DLY_W'(1)) active <= 1'b0;
            cnt <= cnt - DLY_W'(1);
        end
    end

    // R7
    cnt_live_chk: assert property (@(posedge clk) disable iff (rst)
        active |-> (cnt != '0));

endmodule

// File: rtl/cart_dma_ctrl.sv
module cart_dma_ctrl
    import cdma_pkg::*;
#(
    parameter int unsigned DRAM_AW  = 24,
    parameter int unsigned CART_AW  = 32,
    parameter int unsigned LEN_W    = 24,
    parameter int unsigned DLY_W    = 40,
    parameter logic [7:0]  DOM2_TAG = 8'h08
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [3:0]         reg_word,
    input  logic               reg_we,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               dram_req,
    output logic               dram_we,
    output logic [DRAM_AW-1:0] dram_addr,
    output logic [7:0]         dram_wdata,
    input  logic [7:0]         dram_rdata,
    input  logic               dram_ack,
    output logic               cart_req,
    output logic               cart_we,
    output logic [CART_AW-1:0] cart_addr,
    output logic [7:0]         cart_wdata,
    input  logic [7:0]         cart_rdata,
    input  logic               cart_ack,
    output logic               irq
);

    logic               busy;
    logic               mv_active;
    logic               dl_active;
    logic               go;
    xfer_dir_e          go_dir;
    logic [LEN_W-1:0]   go_len;
    logic [DRAM_AW-1:0] dram_q;
    logic [CART_AW-1:0] cart_q;
    dom_timing_t        tim_dom1;
    dom_timing_t        tim_dom2;
    logic               done;
    logic               expire;
    logic [DRAM_AW-1:0] dram_next;
    logic [CART_AW-1:0] cart_next;
    logic [7:0]         xfer_tag;
    logic [LEN_W:0]     xfer_n;

    assign busy = mv_active || dl_active;

    cdma_regfile #(.DRAM_AW(DRAM_AW), .CART_AW(CART_AW), .LEN_W(LEN_W)) u_regs (
        .clk(clk), .rst(rst),
        .reg_word(reg_word), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy), .done(done), .dram_next(dram_next), .cart_next(cart_next),
        .expire(expire), .go(go), .go_dir(go_dir), .go_len(go_len),
        .dram_q(dram_q), .cart_q(cart_q), .tim_dom1(tim_dom1), .tim_dom2(tim_dom2),
        .irq(irq)
    );

    cdma_mover #(.DRAM_AW(DRAM_AW), .CART_AW(CART_AW), .LEN_W(LEN_W)) u_mover (
        .clk(clk), .rst(rst),
        .go(go), .go_dir(go_dir), .go_len(go_len),
        .dram_base(dram_q), .cart_base(cart_q),
        .dram_req(dram_req), .dram_we(dram_we), .dram_addr(dram_addr),
        .dram_wdata(dram_wdata), .dram_rdata(dram_rdata), .dram_ack(dram_ack),
        .cart_req(cart_req), .cart_we(cart_we), .cart_addr(cart_addr),
        .cart_wdata(cart_wdata), .cart_rdata(cart_rdata), .cart_ack(cart_ack),
        .active(mv_active), .done(done),
        .dram_next(dram_next), .cart_next(cart_next),
        .xfer_tag(xfer_tag), .xfer_n(xfer_n)
    );

    cdma_delay #(.LEN_W(LEN_W), .DLY_W(DLY_W), .DOM2_TAG(DOM2_TAG)) u_delay (
        .clk(clk), .rst(rst),
        .done(done), .xfer_tag(xfer_tag), .xfer_n(xfer_n),
        .tim_dom1(tim_dom1), .tim_dom2(tim_dom2),
        .active(dl_active), .expire(expire)
    );

    // R7
    busy_irq_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> irq);

    // R7
    go_busy_chk: assert property (@(posedge clk) disable iff (rst)
        go |=> busy);

endmodule

// File: tb/test_cart_dma_ctrl.sv
module test_cart_dma_ctrl;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  reg_word = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dram_req, dram_we, cart_req, cart_we, irq;
    logic [23:0] dram_addr;
    logic [31:0] cart_addr;
    logic [7:0]  dram_wdata, cart_wdata, dram_rdata, cart_rdata;
    logic        dram_ack, cart_ack;

    logic [7:0]  dram_mem [256];
    logic [7:0]  cart_mem [256];
    logic        stall_en = 1'b0;
    int          tick = 0;
    int          dst_writes = 0;
    int          hold_bad = 0;
    int          checks = 0;
    int          fails = 0;
    logic        pd_wait = 1'b0, pc_wait = 1'b0;
    logic [23:0] pd_addr = '0;
    logic [31:0] pc_addr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cart_dma_ctrl i_cart_dma_ctrl (
        .clk(clk), .rst(rst),
        .reg_word(reg_word), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dram_req(dram_req), .dram_we(dram_we), .dram_addr(dram_addr),
        .dram_wdata(dram_wdata), .dram_rdata(dram_rdata), .dram_ack(dram_ack),
        .cart_req(cart_req), .cart_we(cart_we), .cart_addr(cart_addr),
        .cart_wdata(cart_wdata), .cart_rdata(cart_rdata), .cart_ack(cart_ack),
        .irq(irq)
    );

    logic stall;
    assign stall      = stall_en && ((tick % 3) == 1);
    assign dram_ack   = dram_req && !stall;
    assign cart_ack   = cart_req && !stall;
    assign dram_rdata = dram_mem[dram_addr[7:0]];
    assign cart_rdata = cart_mem[cart_addr[7:0]];

    always @(posedge clk) begin
        tick <= tick + 1;
        if (!rst) begin
            if (dram_req && dram_we && dram_ack) begin
                dram_mem[dram_addr[7:0]] <= dram_wdata;
                dst_writes <= dst_writes + 1;
            end
            if (cart_req && cart_we && cart_ack) begin
                cart_mem[cart_addr[7:0]] <= cart_wdata;
                dst_writes <= dst_writes + 1;
            end
            // R11 monitor: a pending request must persist with the same address
            if (pd_wait && !(dram_req && dram_addr == pd_addr)) hold_bad <= hold_bad + 1;
            if (pc_wait && !(cart_req && cart_addr == pc_addr)) hold_bad <= hold_bad + 1;
            if (dram_req && cart_req) hold_bad <= hold_bad + 1;
            pd_wait <= dram_req && !dram_ack;
            pc_wait <= cart_req && !cart_ack;
            pd_addr <= dram_addr;
            pc_addr <= cart_addr;
        end
    end

    task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] w, input logic [31:0] d);
        @(negedge clk);
        reg_word = w; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] w, output logic [31:0] d);
        reg_word = w;
        #1;
        d = reg_rdata;
    endtask

    function automatic int exp_delay(input int lat, input int pwd, input int pgs, input int rls, input int n);
        int psz, pages;
        psz   = 1 << (pgs + 2);
        pages = (n + psz - 1) / psz;
        return (lat + 20) * pages + (pwd + rls + 2) * (n / 2);
    endfunction

    task automatic run_xfer(input int dir, input int n, input logic [31:0] db, input logic [31:0] cb,
                            input int dly, input bit timed);
        logic [31:0] v, dexp, cexp, dm, cm;
        int c, busy_bad, data_bad, w0;
        reg_write(4'd0, db);
        reg_write(4'd1, cb);
        dm = db & 32'h00FF_FFFE;
        cm = cb & 32'hFFFF_FFFE;
        w0 = dst_writes;
        // R3: upper junk above bit 23 must be dropped
        reg_write(dir ? 4'd3 : 4'd2, 32'h5A00_0000 | 32'(n - 1));
        reg_read(4'd4, v);
        c = 0; busy_bad = 0;
        if (v[0] !== 1'b1) busy_bad++;
        while (!irq && c < 3000) begin
            @(negedge clk);
            c++;
            #1;
            if (!irq && reg_rdata[0] !== 1'b1) busy_bad++;
            if (irq && reg_rdata[0] !== 1'b0) busy_bad++;
        end
        check(busy_bad == 0 && irq === 1'b1, "R7 busy held until irq", 64'(busy_bad), 0);
        if (timed) check(c == 2*n + dly, "R7 cycles to irq", 64'(c), 64'(2*n + dly));
        reg_read(4'd4, v);
        check(v == 32'h8, "R6 status after completion", 64'(v), 64'h8);
        data_bad = 0;
        for (int k = 0; k < n; k++) begin
            if (dir == 0) begin
                if (cart_mem[8'(cm + 32'(k))] !== dram_mem[8'(dm + 32'(k))]) data_bad++;
            end else begin
                if (dram_mem[8'(dm + 32'(k))] !== cart_mem[8'(cm + 32'(k))]) data_bad++;
            end
        end
        check(data_bad == 0, dir ? "R4 cart to dram data" : "R4 dram to cart data", 64'(data_bad), 0);
        check(dst_writes - w0 == n, "R3 byte count", 64'(dst_writes - w0), 64'(n));
        reg_read(dir ? 4'd3 : 4'd2, v);
        check(v == 32'(n - 1), "R3 length readback", 64'(v), 64'(n - 1));
        dexp = ((dm + 32'(n) + 32'd7) & 32'hFFFF_FFF8) & 32'h00FF_FFFF;
        cexp = (cm + 32'(n) + 32'd1) & 32'hFFFF_FFFE;
        reg_read(4'd0, v);
        check(v == dexp, "R5 dram address update", 64'(v), 64'(dexp));
        reg_read(4'd1, v);
        check(v == cexp, "R5 cart address update", 64'(v), 64'(cexp));
        reg_write(4'd4, 32'h0000_0001);
        check(irq === 1'b1, "R8 clear without bit1 keeps irq", 64'(irq), 1);
        reg_write(4'd4, 32'h0000_0002);
        check(irq === 1'b0, "R8 clear with bit1", 64'(irq), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R7 watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v, prev_wr;
        int w0;
        for (int i = 0; i < 256; i++) begin
            dram_mem[i] = 8'(i * 7 + 3);
            cart_mem[i] = 8'(i) ^ 8'hA5;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int i = 0; i < 13; i++) begin
            reg_read(4'(i), v);
            check(v == 0, "R1 register zero after reset", 64'(v), 0);
        end
        check(irq === 1'b0 && dram_req === 1'b0 && cart_req === 1'b0, "R1 outputs idle",
              64'({irq, dram_req, cart_req}), 0);

        // R2 address masks
        reg_write(4'd0, 32'hFFFF_FFFF);
        reg_read(4'd0, v);
        check(v == 32'h00FF_FFFE, "R2 dram address mask", 64'(v), 64'h00FF_FFFE);
        reg_write(4'd1, 32'hFFFF_FFFF);
        reg_read(4'd1, v);
        check(v == 32'hFFFF_FFFE, "R2 cart address mask", 64'(v), 64'hFFFF_FFFE);

        // R10 timing registers keep 8 bits each
        for (int i = 0; i < 8; i++) reg_write(4'(5 + i), 32'hABCD_0000 | 32'(i * 17 + 1));
        for (int i = 0; i < 8; i++) begin
            reg_read(4'(5 + i), v);
            check(v == 32'(8'(i * 17 + 1)), "R10 timing register readback", 64'(v), 64'(8'(i * 17 + 1)));
        end
        for (int i = 0; i < 4; i++) reg_write(4'(5 + i), 32'h0);
        reg_write(4'd9, 32'd3);
        reg_write(4'd10, 32'd1);
        reg_write(4'd11, 32'd1);
        reg_write(4'd12, 32'd2);

        // Sweep: both directions, stalled and ready memories, lengths 1..9, domain 1
        for (int s = 0; s < 2; s++) begin
            for (int d = 0; d < 2; d++) begin
                for (int n = 1; n <= 9; n++) begin
                    stall_en = (s == 1);
                    run_xfer(d, n, 32'h11 + 32'(n * 3) + 32'(s * 64),
                             32'h1000_0041 + 32'(n * 5) + 32'(d * 16) + 32'(s * 64),
                             exp_delay(0, 0, 0, 0, n), s == 0);
                end
            end
        end
        stall_en = 1'b0;

        // R10 domain 2 timing selected by cartridge tag 0x08
        run_xfer(0, 6, 32'h0000_0090, 32'h0800_0011, exp_delay(3, 1, 1, 2, 6), 1'b1);
        run_xfer(1, 13, 32'h0000_00A3, 32'h0800_0031, exp_delay(3, 1, 1, 2, 13), 1'b1);

        // R9 length write while busy is ignored
        reg_read(4'd3, prev_wr);
        reg_write(4'd0, 32'h0000_00C0);
        reg_write(4'd1, 32'h1000_0020);
        w0 = dst_writes;
        reg_write(4'd2, 32'd7);
        reg_write(4'd3, 32'd3);
        reg_read(4'd3, v);
        check(v == prev_wr, "R9 length register unchanged while busy", 64'(v), 64'(prev_wr));
        for (int c = 0; c < 2000 && !irq; c++) @(negedge clk);
        check(dst_writes - w0 == 8, "R9 only first transfer moved bytes", 64'(dst_writes - w0), 8);
        reg_write(4'd4, 32'h2);
        repeat (60) @(negedge clk);
        check(irq === 1'b0 && dst_writes - w0 == 8, "R9 no deferred transfer",
              64'(dst_writes - w0), 8);

        check(hold_bad == 0, "R11 request hold and port exclusion", 64'(hold_bad), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule